// File: doc/BRIEF.md
# Multi-Mode Delay Timer Cell

A synchronous timer cell modelled on the timer instruction of a programmable logic controller. A two-bit mode code selects one of three behaviours at run time: delayed switch-on, delayed switch-off, or a retriggerable single pulse. The cell takes a level input called `enable` and drives one output bit `q`. It also reports how far the current interval has run.

Time is measured in pulses of an external time-base strobe `tick`, nominally one every 100 ms. The preset is given in whole units, nominally seconds. The cell multiplies it by the parameter `TICKS_PER_UNIT` (default 10) to get the terminal count. The elapsed count never passes that terminal count.

A controller instantiates one cell for each timer it needs. It supplies the strobe and the preset, and reads `q` as the timer contact.

Top module: `plc_delay_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge sets `q` to 0 and `elapsed` to 0.
- R2: The terminal count equals `preset * TICKS_PER_UNIT` ticks. With the default of 10, preset 2 gives 20 ticks.
- R3: In mode 2'b00 (on-delay), with `enable` held high, `elapsed` goes up by one on each edge where `tick` is high. `q` goes to 1 on the edge where `elapsed` reaches the terminal count.
- R4: In on-delay mode, any edge with `enable` low sets `q` to 0 and `elapsed` to 0, so a later high period starts again from zero.
- R5: In mode 2'b01 (off-delay), an edge with `enable` high sets `q` to 1 and `elapsed` to 0. After `enable` falls, `q` stays 1 while ticks are counted. It goes to 0 on the edge where `elapsed` reaches the terminal count, and `elapsed` then holds there.
- R6: In mode 2'b10 (retriggerable pulse), an edge that sees `enable` high after a low sample on the edge before sets `q` to 1 and `elapsed` to 0. `q` returns to 0 on the edge where `elapsed` reaches the terminal count, even if `enable` is still high. A falling `enable` does not stop the pulse.
- R7: In pulse mode, a new low-to-high transition of `enable` during a running pulse restarts `elapsed` from 0 and keeps `q` at 1.
- R8: With mode 2'b11 (reserved), every edge sets `q` to 0 and `elapsed` to 0, whatever `enable` and `tick` do.
- R9: `elapsed` never exceeds the terminal count. Further ticks leave it at the terminal count.
- R10: On an edge where the mode code differs from its value at the previous edge, `q` and `elapsed` are both set to 0, and the new mode starts from that state.
- R11: `elapsed` never goes up on an edge where `tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Timer input level |
| tick | input | 1 | Time-base strobe, one clock wide per base period |
| preset | input | PRESET_W | Preset in whole units |
| mode | input | 2 | 00 on-delay, 01 off-delay, 10 pulse, 11 reserved |
| q | output | 1 | Timer output bit |
| elapsed | output | PRESET_W+clog2(TICKS_PER_UNIT) | Ticks counted in the current interval |

## Verification
The saturation check (R9) assumes that `preset` stays constant between two consecutive edges; it ignores the single cycle after a change, during which the count is clamped. The stimulus changes `preset` only while the count is cleared. The checks on tick counting and mode changes assume that `rst_n` is low from time zero, so that every register holds a known value before the first comparison. Every input, `tick` included, changes on the falling clock edge. Each expected value is therefore the result of exactly one rising edge.

// File: rtl/plc_tmr_pkg.sv
// Package: shared mode encoding for the multi-mode delay timer.
// Assumes: the two-bit mode code is decoded identically by every submodule.
package plc_tmr_pkg;
    typedef enum logic [1:0] {
        TM_ON    = 2'b00,
        TM_OFF   = 2'b01,
        TM_PULSE = 2'b10,
        TM_RSV   = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/tmr_history.sv
// Module: tmr_history
// Keeps one-edge-old copies of enable and the mode code.
// Produces the enable rising-edge strobe and the mode-change strobe.
// Assumes: enable and mode are synchronous to clk.
module tmr_history (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] mode,
    output logic       rise,
    output logic       mode_chg
);
    import plc_tmr_pkg::*;

    logic       en_d;
    logic [1:0] mode_d;

    // Register the previous enable level and mode code on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d   <= 1'b0;
            mode_d <= TM_ON;
        end else begin
            en_d   <= enable;
            mode_d <= mode;
        end
    end

    // Strobes derived from the current inputs and their stored copies.
    always_comb begin
        rise     = enable & ~en_d;
        mode_chg = (mode != mode_d);
    end
endmodule

// File: rtl/tmr_elapsed.sv
// Module: tmr_elapsed
// Elapsed-tick counter with clear, tick-gated advance and saturation at
// the terminal count.
// Assumes: clr takes priority over run, and target may change at any edge.
// A count above a lowered target is clamped to that target.
module tmr_elapsed #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] target,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt
);
    // Next count: clear, clamp, advance on a tick, or hold.
    always_comb begin
        if (clr)
            cnt_nxt = '0;
        else if (cnt_q > target)
            cnt_nxt = target;
        else if (run && tick && (cnt_q < target))
            cnt_nxt = cnt_q + CW'(1);
        else
            cnt_nxt = cnt_q;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    // R9: while the target is steady, the count stays within it.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(target) |-> (cnt_q <= target));

    // R11: the count rises only by one, and only after a ticked, running edge.
    assert_tick_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_q <= $past(cnt_q)) ||
                  ((cnt_q == $past(cnt_q) + CW'(1)) && $past(tick) && $past(run))));
endmodule

// File: rtl/tmr_ctl.sv
// Module: tmr_ctl
// Per-mode control. It decides whether the count is cleared or running
// and holds the output bit.
// Assumes: cnt_nxt is the counter's next value for the clr/run given here.
// A mode change overrides every mode rule.
module tmr_ctl #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          enable,
    input  logic          rise,
    input  logic          mode_chg,
    input  logic [CW-1:0] target,
    input  logic [CW-1:0] cnt_nxt,
    output logic          clr,
    output logic          run,
    output logic          q
);
    import plc_tmr_pkg::*;

    tmr_mode_e md;
    logic      q_nxt;

    assign md = tmr_mode_e'(mode);

    // Mode rules: clear/run requests and the next output level.
    always_comb begin
        clr   = 1'b0;
        run   = 1'b0;
        q_nxt = 1'b0;
        if (mode_chg) begin
            clr = 1'b1;
        end else begin
            unique case (md)
                TM_ON: begin
                    if (!enable) begin
                        clr = 1'b1;
                    end else begin
                        run   = 1'b1;
                        q_nxt = (cnt_nxt == target);
                    end
                end
                TM_OFF: begin
                    if (enable) begin
                        clr   = 1'b1;
                        q_nxt = 1'b1;
                    end else if (q) begin
                        run   = 1'b1;
                        q_nxt = (cnt_nxt < target);
                    end
                end
                TM_PULSE: begin
                    if (rise) begin
                        clr   = 1'b1;
                        q_nxt = (target != '0);
                    end else if (q) begin
                        run   = 1'b1;
                        q_nxt = (cnt_nxt < target);
                    end
                end
                default: begin
                    clr = 1'b1;
                end
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= q_nxt;
    end

    // R5: an off-delay edge with enable high leaves the output set.
    assert_off_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (md == TM_OFF && !mode_chg && enable) |=> q);

    // R6: a pulse-mode rising edge with a nonzero target fires the output.
    assert_pulse_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (md == TM_PULSE && !mode_chg && rise && target != '0) |=> q);
endmodule

// File: rtl/plc_delay_timer.sv
// Module: plc_delay_timer (top)
// Multi-mode delay timer: on-delay, off-delay or retriggerable pulse,
// counted in external time-base ticks.
// Assumes: tick is one clock wide. The terminal count is
// preset * TICKS_PER_UNIT.
module plc_delay_timer #(
    parameter int PRESET_W       = 8,
    parameter int TICKS_PER_UNIT = 10,
    localparam int CW            = PRESET_W + $clog2(TICKS_PER_UNIT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tick,
    input  logic [PRESET_W-1:0] preset,
    input  logic [1:0]          mode,
    output logic                q,
    output logic [CW-1:0]       elapsed
);
    import plc_tmr_pkg::*;

    localparam logic [CW-1:0] SCALE = CW'(TICKS_PER_UNIT);

    logic          rise;
    logic          mode_chg;
    logic          clr;
    logic          run;
    logic [CW-1:0] target;
    logic [CW-1:0] cnt_nxt;

    // Terminal count in ticks from the unit preset.
    always_comb target = CW'(preset) * SCALE;

    tmr_history u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .mode     (mode),
        .rise     (rise),
        .mode_chg (mode_chg)
    );

    tmr_ctl #(.CW(CW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .enable   (enable),
        .rise     (rise),
        .mode_chg (mode_chg),
        .target   (target),
        .cnt_nxt  (cnt_nxt),
        .clr      (clr),
        .run      (run),
        .q        (q)
    );

    tmr_elapsed #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .run     (run),
        .tick    (tick),
        .target  (target),
        .cnt_q   (elapsed),
        .cnt_nxt (cnt_nxt)
    );

    // R10: a mode change leaves output and count cleared.
    assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (!q && elapsed == '0));

    // R4: on-delay with enable low drops output and count.
    assert_on_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_ON && !mode_chg && !enable) |=> (!q && elapsed == '0));

    // R8: after an edge in the reserved mode, output and count are zero.
    assert_rsv_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TM_RSV) |=> (!q && elapsed == '0));
endmodule

// File: tb/plc_delay_timer_tb.sv
// Scoreboard bench: the driver pushes the expected result of each edge,
// and the monitor pops it and compares it shortly after that edge.
module plc_delay_timer_tb;
    localparam int PW = 8;
    localparam int CW = PW + $clog2(10);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          tick = 1'b0;
    logic [PW-1:0] preset = 8'd1;
    logic [1:0]    mode = 2'b00;
    logic          q;
    logic [CW-1:0] elapsed;

    typedef struct {
        logic  q;
        int    el;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    logic rn = 1'b0;
    bit   done = 1'b0;

    plc_delay_timer #(.PRESET_W(PW), .TICKS_PER_UNIT(10)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick),
        .preset  (preset),
        .mode    (mode),
        .q       (q),
        .elapsed (elapsed)
    );

    always #10 clk = ~clk;

    // Driver: one edge of stimulus and its expected result.
    task automatic st(input logic en, input logic tk, input logic [1:0] md,
                      input logic eq, input int eel, input string tag);
        exp_t it;
        @(negedge clk);
        rst_n  = rn;
        enable = en;
        tick   = tk;
        mode   = md;
        it.q   = eq;
        it.el  = eel;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare after each rising edge.
    always @(posedge clk) begin
        exp_t it;
        #2;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (q !== it.q || int'(elapsed) != it.el) begin
                errors++;
                $display("FAIL %s q=%0b exp %0b elapsed=%0d exp %0d",
                         it.tag, q, it.q, elapsed, it.el);
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        rn = 1'b0;
        for (int i = 0; i < 3; i++) st(1, 1, 2'b00, 0, 0, "R1 reset");
        rn = 1'b1;
        preset = 8'd1;
        // R11: no tick, no advance
        st(1, 0, 2'b00, 0, 0, "R11 no tick");
        // R3: on-delay count to 10
        for (int i = 1; i <= 10; i++) st(1, 1, 2'b00, (i == 10), i, "R3 on-delay");
        // R9: saturation
        st(1, 1, 2'b00, 1, 10, "R9 saturate");
        st(1, 1, 2'b00, 1, 10, "R9 saturate");
        st(1, 0, 2'b00, 1, 10, "R11 hold");
        // R4: drop and restart
        st(0, 1, 2'b00, 0, 0, "R4 drop");
        for (int i = 1; i <= 4; i++) st(1, 1, 2'b00, 0, i, "R3 partial");
        st(0, 1, 2'b00, 0, 0, "R4 drop partial");
        st(1, 1, 2'b00, 0, 1, "R4 restart");
        // R2: preset 2 gives 20 ticks
        st(0, 0, 2'b00, 0, 0, "R4 idle");
        preset = 8'd2;
        for (int i = 1; i <= 20; i++) st(1, 1, 2'b00, (i == 20), i, "R2 scale");
        // R10: mode change to off-delay
        st(1, 1, 2'b01, 0, 0, "R10 mode change");
        preset = 8'd1;
        st(1, 1, 2'b01, 1, 0, "R5 enable high");
        // R5: off-delay run-out
        for (int i = 1; i <= 5; i++) st(0, 1, 2'b01, 1, i, "R5 hold");
        st(0, 0, 2'b01, 1, 5, "R11 off no tick");
        for (int i = 6; i <= 10; i++) st(0, 1, 2'b01, (i != 10), i, "R5 run-out");
        st(0, 1, 2'b01, 0, 10, "R5 after");
        st(1, 1, 2'b01, 1, 0, "R5 re-enable");
        for (int i = 1; i <= 3; i++) st(0, 1, 2'b01, 1, i, "R5 partial");
        st(1, 1, 2'b01, 1, 0, "R5 restart");
        // R6: pulse mode
        st(0, 1, 2'b10, 0, 0, "R10 to pulse");
        st(0, 1, 2'b10, 0, 0, "R6 idle");
        st(1, 1, 2'b10, 1, 0, "R6 fire");
        for (int i = 1; i <= 10; i++) st(1, 1, 2'b10, (i != 10), i, "R6 pulse");
        st(1, 1, 2'b10, 0, 10, "R6 off while high");
        // R7: retrigger
        st(0, 1, 2'b10, 0, 10, "R7 low");
        st(1, 1, 2'b10, 1, 0, "R7 fire");
        for (int i = 1; i <= 5; i++) st(1, 1, 2'b10, 1, i, "R7 run");
        st(0, 1, 2'b10, 1, 6, "R6 fall keeps pulse");
        st(1, 1, 2'b10, 1, 0, "R7 retrigger");
        st(1, 1, 2'b10, 1, 1, "R7 run again");
        // R8: reserved code
        st(1, 1, 2'b11, 0, 0, "R8 enter");
        st(0, 1, 2'b11, 0, 0, "R8 reserved");
        st(1, 1, 2'b11, 0, 0, "R8 reserved");
        st(1, 0, 2'b11, 0, 0, "R8 reserved");
        // R10: back to on-delay
        st(1, 1, 2'b00, 0, 0, "R10 to on");
        st(1, 1, 2'b00, 0, 1, "R10 fresh start");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule